// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. A start request launches a scan that converts channels one after another, beginning at channel 1. Each channel passes through a fixed series of phases. There is a two-clock initial sample, then a one-clock transfer, then a final sample whose length is programmable. After that comes a resolution phase that spends one converter clock on each result bit. A single end-of-conversion clock closes the channel.

During resolution the controller drives the trial code out to an external DAC. It reads back one comparator bit and uses it to decide whether the bit under test stays set. The finished code goes into that channel's result register, and the channel's completion flag is raised. A scan covers either four or eight channels. A scan-done flag is raised after the last channel.

All phase timing advances only on clock cycles in which the converter clock enable is high. This lets the block run from a divided clock without a second clock domain. The channel-select output drives the external input multiplexer.

Top module: `sar_adc_seq`

## Requirements
- R1: With the sequencer idle, `start` high at a clock edge begins a scan: `busy` goes high and `ch_sel` is 0 (channel 1). A `start` seen while `busy` is high has no effect on the scan, the flags or the timing.
- R2: An accepted `start` clears every bit of `ccf` and clears `scf` at that same edge. Result registers keep their old contents.
- R3: Each channel takes, in enabled clocks: 2 of initial sample, 1 of transfer, `fs_cfg`+1 of final sample, N of resolution (N=10 when `wide_mode`=1, N=8 otherwise) and 1 of end of conversion. Clocks with `adc_ce`=0 do not advance any phase.
- R4: On the first clock of resolution, `dac_code` holds only the most significant bit of the selected width: 512 in 10-bit mode and 128 in 8-bit mode. All other bits are zero. The accepted `start` sets `dac_code` to 0.
- R5: On each resolution clock, `cmp_hi`=1 (DAC code above the input) clears the bit under test, and `cmp_hi`=0 keeps it. The next lower bit is then set. Bits are resolved from the most significant bit down. The final code is the largest code whose value does not exceed the input.
- R6: At the end-of-conversion clock, the code is copied into that channel's result register, `results[10*k +: 10]` for channel index k. `ccf[k]` is set at the same edge.
- R7: In 8-bit mode, a result occupies bits 7:0 of its register, and bits 9:8 are 0.
- R8: Channels are converted in ascending index order. With `eight_ch`=0, the scan ends after index 3: `scf` is set, `busy` drops, and `ccf` reads 0x0F. With `eight_ch`=1, it ends after index 7 and `ccf` reads 0xFF.
- R9: `wide_mode`, `eight_ch` and `fs_cfg` are captured at the accepted `start`. Changes to them during a scan have no effect on that scan.
- R10: After reset, `busy`, `scf`, `ccf`, `dac_code`, `ch_sel` and all results are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_ce | input | 1 | Converter clock enable; phases advance only when high |
| start | input | 1 | Scan request, honoured only when idle |
| cmp_hi | input | 1 | Comparator: 1 when the DAC code exceeds the sampled input |
| wide_mode | input | 1 | 1 selects 10-bit, 0 selects 8-bit resolution |
| eight_ch | input | 1 | 1 selects an 8-channel scan, 0 a 4-channel scan |
| fs_cfg | input | 3 | Final sample length minus one, in enabled clocks |
| dac_code | output | 10 | Trial code for the external DAC |
| ch_sel | output | 3 | Index of the channel being converted |
| busy | output | 1 | High while a scan is in progress |
| results | output | 80 | Eight 10-bit result registers, channel index k at bits 10k+9..10k |
| ccf | output | 8 | Per-channel conversion-complete flags |
| scf | output | 1 | Scan-complete flag |

## Verification
Several properties are checked on every cycle. The assertions confirm that the captured configuration holds still while the sequencer is busy. They confirm that resolution starts from the most-significant-bit code and never disturbs bits already resolved. They also confirm that completion flags only rise during a scan, that channels advance by one, that 8-bit results keep their upper bits clear, and that the scan-done flag is never high while busy.

Some behaviour only the bench scenarios can show. These are the exact phase lengths, the cycle on which each flag rises, and the correctness of the converted codes against a modelled comparator. They also include the effect of a stalled clock enable, the rejection of a start request and configuration changes in mid-scan, and the clearing of flags on a new start.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int RES_W    = 10;
    localparam int NARROW_W = 8;
    localparam int MAX_CH   = 8;
    localparam int CH_W     = $clog2(MAX_CH);
    localparam int FS_W     = 3;
    localparam int SMP_INIT = 2;
    localparam int BI_W     = $clog2(RES_W);
    localparam int BANK_W   = MAX_CH * RES_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ISMP,
        PH_XFR,
        PH_FSMP,
        PH_RES,
        PH_EOC
    } phase_e;

    typedef struct packed {
        logic            wide;
        logic            eight;
        logic [FS_W-1:0] fs;
    } cfg_t;

    function automatic logic [BI_W-1:0] top_bit(input logic wide);
        return wide ? BI_W'(RES_W - 1) : BI_W'(NARROW_W - 1);
    endfunction

    function automatic logic [RES_W-1:0] msb_code(input logic wide);
        logic [RES_W-1:0] v;
        v = '0;
        v[top_bit(wide)] = 1'b1;
        return v;
    endfunction

    function automatic logic [CH_W-1:0] last_ch(input logic eight);
        return eight ? CH_W'(MAX_CH - 1) : CH_W'(MAX_CH / 2 - 1);
    endfunction

endpackage

// File: rtl/sar_timeline.sv
module sar_timeline
    import sar_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ce,
    input  logic            start,
    input  cfg_t            cfg_in,
    output cfg_t            cfg,
    output logic            busy,
    output logic [CH_W-1:0] ch,
    output logic [BI_W-1:0] bi,
    output logic            accept,
    output logic            sar_ld,
    output logic            sar_step,
    output logic            eoc_wr,
    output logic            seq_done
);

    phase_e          phase;
    logic [FS_W-1:0] cnt;

    assign accept   = start && (phase == PH_IDLE);
    assign busy     = (phase != PH_IDLE);
    assign sar_ld   = ce && (phase == PH_FSMP) && (cnt == cfg.fs);
    assign sar_step = ce && (phase == PH_RES);
    assign eoc_wr   = ce && (phase == PH_EOC);
    assign seq_done = eoc_wr && (ch == last_ch(cfg.eight));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            ch    <= '0;
            bi    <= '0;
            cfg   <= '0;
        end else if (accept) begin
            phase <= PH_ISMP;
            cnt   <= '0;
            ch    <= '0;
            cfg   <= cfg_in;
        end else if (ce) begin
            case (phase)
                PH_ISMP: begin
                    if (cnt == FS_W'(SMP_INIT - 1)) begin
                        phase <= PH_XFR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_XFR: begin
                    phase <= PH_FSMP;
                    cnt   <= '0;
                end
                PH_FSMP: begin
                    if (cnt == cfg.fs) begin
                        phase <= PH_RES;
                        bi    <= top_bit(cfg.wide);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RES: begin
                    if (bi == '0) phase <= PH_EOC;
                    else          bi    <= bi - 1'b1;
                end
                PH_EOC: begin
                    if (ch == last_ch(cfg.eight)) begin
                        phase <= PH_IDLE;
                    end else begin
                        ch    <= ch + 1'b1;
                        phase <= PH_ISMP;
                        cnt   <= '0;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg)) else $error("config changed during scan"); // R9

    AST_CH_STEP: assert property (@(posedge clk) disable iff (rst)
        (eoc_wr && !seq_done) |=> (ch == $past(ch) + 1'b1)) else $error("channel order"); // R8

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy && ch == '0)) else $error("start not taken"); // R1

endmodule

// File: rtl/sar_register.sv
module sar_register
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ld,
    input  logic             step,
    input  logic [BI_W-1:0]  bi,
    input  logic             cmp_hi,
    input  logic             wide,
    output logic [RES_W-1:0] sar
);

    logic [RES_W-1:0] trial;

    always_comb begin
        trial = sar;
        if (cmp_hi) trial[bi] = 1'b0;
        if (bi != '0) trial[BI_W'(bi - 1'b1)] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)   sar <= '0;
        else if (ld)      sar <= msb_code(wide);
        else if (step)    sar <= trial;
    end

    AST_MSB_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr) |=> (sar == msb_code(wide))) else $error("msb load"); // R4

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && !ld) |=> (((sar ^ $past(sar)) >> ($past(bi) + 1'b1)) == '0))
        else $error("resolved bits disturbed"); // R5

endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank
    import sar_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr,
    input  logic              done,
    input  logic              wide,
    input  logic [CH_W-1:0]   ch,
    input  logic [RES_W-1:0]  code,
    output logic [BANK_W-1:0] results,
    output logic [MAX_CH-1:0] ccf,
    output logic              scf
);

    for (genvar g = 0; g < MAX_CH; g++) begin : g_slot
        logic [RES_W-1:0] slot;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot   <= '0;
                ccf[g] <= 1'b0;
            end else if (clr) begin
                ccf[g] <= 1'b0;
            end else if (wr && ch == CH_W'(g)) begin
                slot   <= code;
                ccf[g] <= 1'b1;
            end
        end
        assign results[g*RES_W +: RES_W] = slot;

        AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
            (wr && !clr && !wide && ch == CH_W'(g)) |=> (slot[RES_W-1:NARROW_W] == '0))
            else $error("8-bit result upper bits"); // R7
    end

    always_ff @(posedge clk) begin
        if (rst || clr) scf <= 1'b0;
        else if (done)  scf <= 1'b1;
    end

    AST_FLAGS_RISE: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((ccf & $past(ccf)) == $past(ccf))) else $error("flag dropped"); // R6

    AST_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ccf == '0 && !scf)) else $error("flags not cleared"); // R2

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import sar_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_ce,
    input  logic              start,
    input  logic              cmp_hi,
    input  logic              wide_mode,
    input  logic              eight_ch,
    input  logic [FS_W-1:0]   fs_cfg,
    output logic [RES_W-1:0]  dac_code,
    output logic [CH_W-1:0]   ch_sel,
    output logic              busy,
    output logic [BANK_W-1:0] results,
    output logic [MAX_CH-1:0] ccf,
    output logic              scf
);

    cfg_t            cfg_in, cfg;
    logic [BI_W-1:0] bi;
    logic            accept, sar_ld, sar_step, eoc_wr, seq_done;

    assign cfg_in = '{wide: wide_mode, eight: eight_ch, fs: fs_cfg};

    sar_timeline u_tl (
        .clk      (clk),
        .rst      (rst),
        .ce       (adc_ce),
        .start    (start),
        .cfg_in   (cfg_in),
        .cfg      (cfg),
        .busy     (busy),
        .ch       (ch_sel),
        .bi       (bi),
        .accept   (accept),
        .sar_ld   (sar_ld),
        .sar_step (sar_step),
        .eoc_wr   (eoc_wr),
        .seq_done (seq_done)
    );

    sar_register u_sar (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept),
        .ld     (sar_ld),
        .step   (sar_step),
        .bi     (bi),
        .cmp_hi (cmp_hi),
        .wide   (cfg.wide),
        .sar    (dac_code)
    );

    sar_result_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .wr      (eoc_wr),
        .done    (seq_done),
        .wide    (cfg.wide),
        .ch      (ch_sel),
        .code    (dac_code),
        .results (results),
        .ccf     (ccf),
        .scf     (scf)
    );

    AST_SCF_IDLE: assert property (@(posedge clk) disable iff (rst)
        scf |-> !busy) else $error("scan flag while busy"); // R8

endmodule

// File: tb/sar_adc_seq_test.sv
module sar_adc_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wide_mode = 1'b0;
    logic        eight_ch = 1'b0;
    logic [2:0]  fs_cfg = 3'd0;
    logic        ce_div = 1'b0;
    logic        ce_tog = 1'b0;
    logic        adc_ce;
    logic        cmp_hi;
    logic [9:0]  dac_code;
    logic [2:0]  ch_sel;
    logic        busy;
    logic [79:0] results;
    logic [7:0]  ccf;
    logic        scf;
    logic [9:0]  vin [8];

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    always @(negedge clk) ce_tog <= ~ce_tog;
    assign adc_ce = ce_div ? ce_tog : 1'b1;
    assign cmp_hi = (dac_code > vin[ch_sel]);

    sar_adc_seq uut (
        .clk(clk), .rst(rst), .adc_ce(adc_ce), .start(start), .cmp_hi(cmp_hi),
        .wide_mode(wide_mode), .eight_ch(eight_ch), .fs_cfg(fs_cfg),
        .dac_code(dac_code), .ch_sel(ch_sel), .busy(busy),
        .results(results), .ccf(ccf), .scf(scf)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            failures++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_vin(input logic [9:0] base);
        for (int k = 0; k < 8; k++) vin[k] = (base ^ 10'(k * 73));
    endtask

    function automatic int exp_code(input int k, input bit w);
        int mx;
        mx = w ? 1023 : 255;
        return (int'(vin[k]) > mx) ? mx : int'(vin[k]);
    endfunction

    // drive start for one cycle; returns at the negedge after the accepting edge
    task automatic kick(input bit w, input bit e, input logic [2:0] fs);
        @(negedge clk);
        wide_mode = w; eight_ch = e; fs_cfg = fs; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(inout int n);
        while (!scf && n < 5000) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
    endtask

    task automatic check_bank(input bit w, input bit e, input string tag);
        int nch;
        nch = e ? 8 : 4;
        for (int k = 0; k < nch; k++) begin
            chk(int'(results[k*10 +: 10]) == exp_code(k, w), "R5", {tag, " result"},
                int'(results[k*10 +: 10]), exp_code(k, w));
            if (!w)
                chk(results[k*10+8 +: 2] == 2'b00, "R7", {tag, " upper bits"},
                    int'(results[k*10+8 +: 2]), 0);
        end
        chk(ccf == (e ? 8'hFF : 8'h0F), "R8", {tag, " ccf"}, int'(ccf), e ? 255 : 15);
        chk(!busy && scf, "R8", {tag, " idle with scf"}, {busy, scf}, 1);
    endtask

    typedef struct packed {
        logic       w;
        logic       e;
        logic [2:0] fs;
        logic       cd;
        logic [9:0] base;
    } vec_t;

    localparam vec_t VT [6] = '{
        '{w: 1'b1, e: 1'b1, fs: 3'd0, cd: 1'b0, base: 10'h000},
        '{w: 1'b1, e: 1'b0, fs: 3'd3, cd: 1'b0, base: 10'h3FF},
        '{w: 1'b0, e: 1'b0, fs: 3'd0, cd: 1'b0, base: 10'h05A},
        '{w: 1'b0, e: 1'b1, fs: 3'd7, cd: 1'b1, base: 10'h3FF},
        '{w: 1'b1, e: 1'b1, fs: 3'd1, cd: 1'b1, base: 10'h2B7},
        '{w: 1'b0, e: 1'b1, fs: 3'd2, cd: 1'b0, base: 10'h0C3}
    };

    initial begin
        int n;
        int t;
        set_vin(10'h000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk(!busy && !scf && ccf == 8'h00, "R10", "flags after reset", {busy, scf, ccf}, 0);
        chk(dac_code == 10'd0 && ch_sel == 3'd0, "R10", "dac/ch after reset",
            int'(dac_code), 0);
        chk(results == '0, "R10", "results after reset", int'(results[9:0]), 0);

        // vector table
        for (int i = 0; i < 6; i++) begin
            ce_div = VT[i].cd;
            set_vin(VT[i].base);
            kick(VT[i].w, VT[i].e, VT[i].fs);
            n = 0;
            wait_done(n);
            t = (int'(VT[i].fs) + (VT[i].w ? 10 : 8) + 5) * (VT[i].e ? 8 : 4);
            if (!VT[i].cd)
                chk(n == t, "R3", $sformatf("vector %0d duration", i), n, t);
            else
                chk(n > t, "R3", $sformatf("vector %0d stalled duration", i), n, t);
            check_bank(VT[i].w, VT[i].e, $sformatf("vector %0d", i));
        end
        ce_div = 1'b0;

        // directed: 8-bit fs=0, T=13; R1, R4, R6 timing, R2 clearing
        set_vin(10'h0F0);
        kick(1'b0, 1'b0, 3'd0);
        chk(busy && ch_sel == 3'd0, "R1", "busy at channel 0", {busy, ch_sel}, 8);
        chk(ccf == 8'h00 && !scf, "R2", "flags cleared by start", {scf, ccf}, 0);
        chk(dac_code == 10'd0, "R4", "dac cleared by start", int'(dac_code), 0);
        n = 0;
        while (n < 4) begin @(posedge clk); n++; @(negedge clk); end
        chk(dac_code == 10'd128, "R4", "8-bit msb code", int'(dac_code), 128);
        while (n < 12) begin @(posedge clk); n++; @(negedge clk); end
        chk(ccf[0] == 1'b0, "R6", "ccf0 before eoc edge", int'(ccf[0]), 0);
        @(posedge clk); n++; @(negedge clk);
        chk(ccf == 8'h01, "R6", "ccf0 at eoc edge", int'(ccf), 1);
        chk(int'(results[9:0]) == exp_code(0, 1'b0), "R6", "result0 at eoc",
            int'(results[9:0]), exp_code(0, 1'b0));
        chk(ch_sel == 3'd1, "R8", "next channel", int'(ch_sel), 1);
        wait_done(n);

        // directed: 10-bit msb with fs=2 -> resolution after 6 enabled clocks
        set_vin(10'h155);
        kick(1'b1, 1'b0, 3'd2);
        n = 0;
        while (n < 5) begin @(posedge clk); n++; @(negedge clk); end
        chk(dac_code == 10'd0, "R4", "dac zero during final sample", int'(dac_code), 0);
        @(posedge clk); n++; @(negedge clk);
        chk(dac_code == 10'd512, "R4", "10-bit msb code", int'(dac_code), 512);
        wait_done(n);
        chk(n == 4 * 17, "R3", "10-bit fs2 duration", n, 68);

        // directed: start and config changes mid-scan are ignored (R1, R9)
        set_vin(10'h05A);
        kick(1'b0, 1'b0, 3'd0);
        n = 0;
        while (n < 20) begin @(posedge clk); n++; @(negedge clk); end
        chk(ccf == 8'h01, "R1", "ccf before ignored start", int'(ccf), 1);
        start = 1'b1; fs_cfg = 3'd7; wide_mode = 1'b1; eight_ch = 1'b1;
        @(posedge clk); n++; @(negedge clk);
        start = 1'b0;
        chk(ccf == 8'h01 && busy, "R1", "ccf kept after ignored start", int'(ccf), 1);
        wait_done(n);
        chk(n == 52, "R9", "duration with changed config", n, 52);
        check_bank(1'b0, 1'b0, "ignored start");

        // R2: new start after completion clears results flags
        kick(1'b0, 1'b1, 3'd0);
        chk(!scf && ccf == 8'h00 && busy, "R2", "restart clears flags", {scf, ccf}, 0);
        chk(int'(results[9:0]) == exp_code(0, 1'b0), "R2", "results kept on restart",
            int'(results[9:0]), exp_code(0, 1'b0));
        n = 0;
        wait_done(n);
        chk(n == 13 * 8, "R8", "8-channel 8-bit duration", n, 104);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule